// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher

This block decides which of a small set of interrupt controllers must receive an interprocessor interrupt request. A request names its sender, carries an 8-bit destination byte, a 2-bit shorthand code, a physical/logical mode flag and a 3-bit delivery code. Every target controller supplies its 8-bit physical ID, its 8-bit logical ID, a 4-bit destination-model code and an enable flag. The block compares the request against all targets in parallel and returns a registered per-target mask.

For fixed delivery the mask lists every matching target. For lowest-priority delivery a rotating selector reduces the matches to one enabled target. It starts after the previous winner, wraps around and keeps that winner as the next starting point. The mask feeds the injection logic of each controller, which is outside this block.

Top module: `ipi_dest_router`

## Requirements
- R1: With shorthand code 2'b01 only the target whose index equals the sender index matches.
- R2: With shorthand code 2'b10 every target matches, the sender included.
- R3: With shorthand code 2'b11 every target except the sender matches.
- R4: With shorthand code 2'b00 and the logical flag at 0 (physical mode), a target matches when the destination byte is 8'hFF or equals the target's physical ID.
- R5: With shorthand 2'b00, logical flag 1 and the target's model code 4'hF (flat), the target matches when its logical ID ANDed with the destination byte is nonzero.
- R6: With shorthand 2'b00, logical flag 1 and model code 4'h0 (cluster), the target matches when bits 7:4 of the logical ID and of the destination are equal and the AND of their bits 3:0 is nonzero.
- R7: In logical mode with shorthand 2'b00, a target whose model code is neither 4'hF nor 4'h0 never matches.
- R8: For any delivery code other than 3'b001 the output mask equals the full match mask, and the enable flags have no effect on it.
- R9: For delivery code 3'b001 (lowest priority) the output is one-hot. It selects the first target that both matches and is enabled, scanning upward from the index after the previous winner and wrapping past the last index.
- R10: When a lowest-priority request finds no matching enabled target, the output mask is zero and the starting point is unchanged, so the next search starts where it would have started before.
- R11: The result appears on the output one clock after the request, with out_valid high for exactly that cycle. Reset clears out_valid and the mask, and it sets the starting point so that the first search begins at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_sender | input | $clog2(N_TGT) | Index of the sending controller |
| req_dest | input | 8 | Destination byte |
| req_short | input | 2 | Shorthand code |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_mode | input | 3 | Delivery code (3'b001 lowest priority) |
| tgt_id | input | 8*N_TGT | Physical IDs, target i in bits 8i+7:8i |
| tgt_logid | input | 8*N_TGT | Logical IDs, same packing |
| tgt_model | input | 4*N_TGT | Destination-model codes, target i in bits 4i+3:4i |
| tgt_enabled | input | N_TGT | Controller enable flags |
| out_valid | output | 1 | Result valid |
| out_mask | output | N_TGT | Selected targets |

## Verification
Destination matching and the rotating selection act on the same request. With shorthand 2'b11 and lowest-priority delivery, the exclusion of the sender decides which bit the selector may take next. The bench makes this happen by sweeping every sender against all 256 enable patterns. It keeps its own copy of the starting point and computes each expected one-hot mask by scanning arithmetically. A wrong exclusion, a wrong wrap or a pointer update on a failed search therefore shows up as a mismatched mask on the following requests.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [2:0] DM_LOWEST     = 3'b001;
  localparam logic [7:0] DEST_BCAST    = 8'hFF;

endpackage

// File: rtl/ipi_tgt_match.sv
module ipi_tgt_match
  import ipi_pkg::*;
#(
  parameter int IDW = 8
) (
  input  logic [IDW-1:0] dest,
  input  logic [1:0]     short_code,
  input  logic           logical,
  input  logic           is_sender,
  input  logic [IDW-1:0] phys_id,
  input  logic [IDW-1:0] log_id,
  input  logic [3:0]     model,
  output logic           hit
);
  localparam int HALF = IDW / 2;

  logic flat_hit, clus_hit, dest_hit;

  always_comb begin
    flat_hit = |(log_id & dest);
    clus_hit = (log_id[IDW-1:HALF] == dest[IDW-1:HALF]) &&
               (|(log_id[HALF-1:0] & dest[HALF-1:0]));
    if (!logical)
      dest_hit = (dest == IDW'(DEST_BCAST)) || (dest == phys_id);
    else if (model == MODEL_FLAT)
      dest_hit = flat_hit;
    else if (model == MODEL_CLUSTER)
      dest_hit = clus_hit;
    else
      dest_hit = 1'b0;
  end

  always_comb begin
    unique case (shorthand_e'(short_code))
      SH_NONE:   hit = dest_hit;
      SH_SELF:   hit = is_sender;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !is_sender;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [N-1:0] cand,
  input  logic [N-1:0] en,
  output logic [N-1:0] pick
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] win_idx;
  logic          found;
  logic [N-1:0]  elig;

  assign elig = cand & en;

  always_comb begin
    found   = 1'b0;
    win_idx = ptr_q;
    for (int k = 1; k <= N; k++) begin
      if (!found && elig[(int'(ptr_q) + k) % N]) begin
        found   = 1'b1;
        win_idx = PW'((int'(ptr_q) + k) % N);
      end
    end
  end

  assign pick = found ? ({{(N-1){1'b0}}, 1'b1} << win_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= PW'(N - 1);
    else if (step && found)
      ptr_q <= win_idx;
  end

  // R10
  ptr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ptr_q));

  // R10
  ptr_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (step && (cand & en) == '0) |=> $stable(ptr_q));

  // R9
  pick_legal_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> ($onehot0(pick) && ((pick & ~(cand & en)) == '0)));

endmodule

// File: rtl/ipi_dest_router.sv
module ipi_dest_router
  import ipi_pkg::*;
#(
  parameter int N_TGT = 8,
  parameter int IDW   = 8,
  parameter int SW    = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [SW-1:0]      req_sender,
  input  logic [IDW-1:0]     req_dest,
  input  logic [1:0]         req_short,
  input  logic               req_logical,
  input  logic [2:0]         req_mode,
  input  logic [N_TGT*IDW-1:0] tgt_id,
  input  logic [N_TGT*IDW-1:0] tgt_logid,
  input  logic [N_TGT*4-1:0] tgt_model,
  input  logic [N_TGT-1:0]   tgt_enabled,
  output logic               out_valid,
  output logic [N_TGT-1:0]   out_mask
);

  logic [N_TGT-1:0] cand;
  logic [N_TGT-1:0] pick;
  logic             is_lowest;

  assign is_lowest = (req_mode == DM_LOWEST);

  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    ipi_tgt_match #(.IDW(IDW)) u_match (
      .dest       (req_dest),
      .short_code (req_short),
      .logical    (req_logical),
      .is_sender  (req_sender == SW'(g)),
      .phys_id    (tgt_id[g*IDW +: IDW]),
      .log_id     (tgt_logid[g*IDW +: IDW]),
      .model      (tgt_model[g*4 +: 4]),
      .hit        (cand[g])
    );
  end

  ipi_rr_pick #(.N(N_TGT)) u_rr (
    .clk  (clk),
    .rst  (rst),
    .step (req_valid && is_lowest),
    .cand (cand),
    .en   (tgt_enabled),
    .pick (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid)
        out_mask <= is_lowest ? pick : cand;
    end
  end

  // R11
  out_valid_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R11
  out_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R2
  all_incl_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_short == SH_ALL && req_mode != DM_LOWEST) |=> (&out_mask));

  // R3
  excl_sender_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_short == SH_OTHERS) |=> !out_mask[$past(req_sender)]);

  // R1
  self_only_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_short == SH_SELF && req_mode != DM_LOWEST)
      |=> (out_mask == ({{(N_TGT-1){1'b0}}, 1'b1} << $past(req_sender))));

  // R9
  lowest_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == DM_LOWEST) |=> $onehot0(out_mask));

endmodule

// File: tb/ipi_dest_router_tb.sv
module ipi_dest_router_tb;
  localparam int N  = 8;
  localparam int SW = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [SW-1:0]  req_sender = '0;
  logic [7:0]     req_dest = '0;
  logic [1:0]     req_short = '0;
  logic           req_logical = 1'b0;
  logic [2:0]     req_mode = '0;
  logic [N*8-1:0] tgt_id;
  logic [N*8-1:0] tgt_logid;
  logic [N*4-1:0] tgt_model;
  logic [N-1:0]   tgt_enabled = '1;
  logic           out_valid;
  logic [N-1:0]   out_mask;

  int n_chk  = 0;
  int n_fail = 0;
  int bptr   = N - 1;
  bit done   = 0;

  always #4 clk = ~clk;

  ipi_dest_router #(.N_TGT(N), .IDW(8)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sender(req_sender),
    .req_dest(req_dest), .req_short(req_short), .req_logical(req_logical),
    .req_mode(req_mode), .tgt_id(tgt_id), .tgt_logid(tgt_logid),
    .tgt_model(tgt_model), .tgt_enabled(tgt_enabled),
    .out_valid(out_valid), .out_mask(out_mask)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_cand(int s, logic [7:0] d,
                                            logic [1:0] sh, logic lg);
    logic [N-1:0] m;
    for (int t = 0; t < N; t++) begin
      logic [7:0] id, lid;
      logic [3:0] md;
      id  = tgt_id[t*8 +: 8];
      lid = tgt_logid[t*8 +: 8];
      md  = tgt_model[t*4 +: 4];
      case (sh)
        2'b01: m[t] = (t == s);
        2'b10: m[t] = 1'b1;
        2'b11: m[t] = (t != s);
        default: begin
          if (!lg)
            m[t] = (d == 8'hFF) || (d == id);
          else if (md == 4'hF)
            m[t] = (lid & d) != 0;
          else if (md == 4'h0)
            m[t] = (lid[7:4] == d[7:4]) && ((lid[3:0] & d[3:0]) != 0);
          else
            m[t] = 1'b0;
        end
      endcase
    end
    return m;
  endfunction

  task automatic send(int s, logic [7:0] d, logic [1:0] sh, logic lg,
                      logic [2:0] md, string tag);
    logic [N-1:0] c, exp;
    @(negedge clk);
    req_valid   = 1'b1;
    req_sender  = SW'(s);
    req_dest    = d;
    req_short   = sh;
    req_logical = lg;
    req_mode    = md;
    c = exp_cand(s, d, sh, lg);
    if (md == 3'b001) begin
      logic [N-1:0] e;
      bit hit;
      e = c & tgt_enabled;
      exp = '0;
      hit = 0;
      for (int k = 1; k <= N; k++) begin
        if (!hit && e[(bptr + k) % N]) begin
          hit  = 1;
          bptr = (bptr + k) % N;
          exp  = N'(1) << bptr;
        end
      end
    end else begin
      exp = c;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R11 valid"}, 32'(out_valid), 32'd1);
    check(tag, 32'(out_mask), 32'(exp));
  endtask

  initial begin
    for (int t = 0; t < N; t++) begin
      tgt_id[t*8 +: 8] = 8'h20 + 8'(t * 5);
      tgt_model[t*4 +: 4] = 4'hF;
      tgt_logid[t*8 +: 8] = (t < 4) ? 8'(1 << t) : 8'h00;
    end
    tgt_logid[4*8 +: 8] = 8'h90;
    tgt_logid[5*8 +: 8] = 8'h12; tgt_model[5*4 +: 4] = 4'h0;
    tgt_logid[6*8 +: 8] = 8'h13; tgt_model[6*4 +: 4] = 4'h0;
    tgt_logid[7*8 +: 8] = 8'hFF; tgt_model[7*4 +: 4] = 4'h5;

    repeat (3) @(negedge clk);
    check("R11 reset valid", 32'(out_valid), 32'd0);
    check("R11 reset mask", 32'(out_mask), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 idle valid", 32'(out_valid), 32'd0);

    // R11: first lowest-priority search starts at index 0
    send(3, 8'hFF, 2'b00, 1'b0, 3'b001, "R11 first pick");

    // R4: physical sweep over all destinations
    for (int d = 0; d < 256; d++)
      send(d % N, 8'(d), 2'b00, 1'b0, 3'b000, "R4 physical");

    // R5 R6 R7: logical sweep, mixed flat / cluster / bad model
    for (int d = 0; d < 256; d++)
      send(0, 8'(d), 2'b00, 1'b1, 3'b000, "R5 R6 R7 logical");

    // R1 R2 R3 R8: shorthands, disabled targets, other delivery codes
    tgt_enabled = 8'h0F;
    for (int sh = 1; sh < 4; sh++)
      for (int s = 0; s < N; s++)
        for (int lg = 0; lg < 2; lg++)
          send(s, 8'(s * 37), 2'(sh), 1'(lg), (s % 2) ? 3'b000 : 3'b110,
               (sh == 1) ? "R1 R8 self" : (sh == 2) ? "R2 R8 all" : "R3 R8 others");

    // R9 R10: rotation across every enable pattern, physical broadcast
    for (int e = 0; e < 256; e++) begin
      tgt_enabled = 8'(e);
      send(0, 8'hFF, 2'b00, 1'b0, 3'b001, (e == 0) ? "R10 none" : "R9 rotate");
    end

    // R10: empty search keeps the starting point
    tgt_enabled = 8'hFF;
    send(0, 8'hFF, 2'b00, 1'b0, 3'b001, "R9 rotate");
    tgt_enabled = 8'h00;
    send(0, 8'hFF, 2'b00, 1'b0, 3'b001, "R10 none");
    tgt_enabled = 8'hFF;
    send(0, 8'hFF, 2'b00, 1'b0, 3'b001, "R10 resume");

    // R3 R9: sender exclusion combined with rotation
    for (int s = 0; s < N; s++)
      for (int e = 0; e < 256; e++) begin
        tgt_enabled = 8'(e);
        send(s, 8'h00, 2'b11, 1'b0, 3'b001, "R3 R9 others lowest");
      end

    // R6 R9: logical lowest priority
    tgt_enabled = 8'hA5;
    for (int d = 0; d < 256; d++)
      send(1, 8'(d), 2'b00, 1'b1, 3'b001, "R6 R9 logical lowest");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule